// File: doc/BRIEF.md
# Transceiver Operating Mode Sequencer

This block keeps the control bits a host writes to steer a radio transceiver and moves the transceiver between four operating states: STANDBY, TUNE, RX and TX. The host writes two small control registers through a single write strobe. The first holds transmit-enable, receive-enable and a PLL-on bit that selects TUNE rather than STANDBY as the idle state. The second holds a multi-packet receive bit and a direct-mode bit.

Entering TX or RX from any other state first passes through a settle interval, shown as TUNE, whose length is set by an input. In packet-buffer mode, a packet-sent pulse ends TX and a packet-valid pulse ends RX. In each case the block clears the matching enable bit itself and falls back to the host-selected idle state. When the multi-packet bit is set, RX is kept after a valid packet and the host decides what happens next. In direct mode the block never exits automatically, so TX or RX lasts exactly as long as the host holds the enable bit.

Top module: `xcvr_mode_seq`

## Requirements
- R1: After reset, state_o reads STANDBY (code 0) and ctl1_o reads 0x00; the multi-packet and direct bits are clear.
- R2: A strobe with wr_addr=0 loads the first register (bit 2 transmit-enable, bit 1 receive-enable, bit 0 PLL-on). A strobe with wr_addr=1 loads the second register (bit 4 multi-packet, bit 0 direct). ctl1_o shows the new value one clock edge after the strobe, and its bits 7..3 always read 0.
- R3: With neither enable set, state_o is TUNE (code 1) when PLL-on is set and STANDBY (code 0) otherwise. The new value appears at the edge that captures the write.
- R4: When an enable takes effect and the block is not already in the matching active state, state_o shows TUNE for max(S,1) cycles, counted from the edge that captures the change, where S is settle_cycles at that edge. It then shows TX (code 3) or RX (code 2).
- R5: If both enables are set, the target is TX and receive-enable has no effect. When transmit-enable later clears, the stored receive-enable leads through the settle interval into RX.
- R6: With direct=0, a packet-sent pulse while in TX clears transmit-enable and moves state_o to the idle state at the same edge.
- R7: With direct=0 and multi-packet=0, a packet-valid pulse while in RX clears receive-enable and moves state_o to the idle state at the same edge.
- R8: With multi-packet=1, a packet-valid pulse in RX leaves state_o at RX and receive-enable set.
- R9: A packet-sent or packet-valid pulse outside its matching active state (during settle or in the other active state) changes neither state_o nor ctl1_o.
- R10: With direct=1, packet-sent and packet-valid pulses change neither state_o nor ctl1_o, so TX and RX last while the enable is held.
- R11: A host write that clears the enables moves state_o from TX, RX or settle to the idle state at the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 1 | 0 selects the first control register, 1 the second |
| wr_data | input | 8 | Write data |
| settle_cycles | input | SETTLE_W | Settle interval length, sampled on entry to settle |
| pkt_sent | input | 1 | One-cycle packet-sent pulse |
| pkt_valid | input | 1 | One-cycle packet-valid pulse |
| state_o | output | 2 | Current state: 0 STANDBY, 1 TUNE, 2 RX, 3 TX |
| ctl1_o | output | 8 | Current first control register (bits 2..0 used) |

## Verification
Register writes, aborts and packet-event exits all show on state_o and ctl1_o one clock edge after the strobe or pulse. The end of settle comes max(S,1) edges after the edge that starts it. The bench drives every input on the falling edge and samples on the following falling edge, so each sample follows exactly one rising edge. A settle check samples TUNE once per cycle for the computed length and then expects the active code. Pulses sent during settle are timed so that the remaining settle samples still line up with the expected interval.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

    localparam logic CTL1_ADDR = 1'b0;
    localparam logic CTL2_ADDR = 1'b1;

    localparam logic [1:0] CODE_STBY = 2'd0;
    localparam logic [1:0] CODE_TUNE = 2'd1;
    localparam logic [1:0] CODE_RX   = 2'd2;
    localparam logic [1:0] CODE_TX   = 2'd3;

    typedef enum logic [2:0] {
        M_STBY,
        M_TUNE,
        M_SETTLE,
        M_RX,
        M_TX
    } mode_e;

    typedef struct packed {
        logic tx_en;
        logic rx_en;
        logic pll_on;
    } ctl1_t;

    typedef struct packed {
        logic multi_pkt;
        logic direct;
    } ctl2_t;

    function automatic mode_e target_of(ctl1_t c);
        if (c.tx_en)       return M_TX;
        else if (c.rx_en)  return M_RX;
        else if (c.pll_on) return M_TUNE;
        else               return M_STBY;
    endfunction

    function automatic logic is_active(mode_e m);
        return (m == M_TX) || (m == M_RX);
    endfunction

    function automatic logic [1:0] code_of(mode_e m);
        case (m)
            M_TX:             return CODE_TX;
            M_RX:             return CODE_RX;
            M_TUNE, M_SETTLE: return CODE_TUNE;
            default:          return CODE_STBY;
        endcase
    endfunction

endpackage

// File: rtl/xcvr_ctl_regs.sv
module xcvr_ctl_regs
    import xcvr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       exit_tx,
    input  logic       exit_rx,
    output ctl1_t      c1_q,
    output ctl1_t      c1_d,
    output ctl2_t      c2_q
);

    ctl2_t c2_d;
    logic  wr1, wr2;
    logic  unused_data_bits;

    assign wr1 = wr_en && (wr_addr == CTL1_ADDR);
    assign wr2 = wr_en && (wr_addr == CTL2_ADDR);
    assign unused_data_bits = ^{wr_data[7:5], wr_data[3]};

    always_comb begin
        c1_d = c1_q;
        if (wr1) begin
            c1_d.tx_en  = wr_data[2];
            c1_d.rx_en  = wr_data[1];
            c1_d.pll_on = wr_data[0];
        end else begin
            if (exit_tx) c1_d.tx_en = 1'b0;
            if (exit_rx) c1_d.rx_en = 1'b0;
        end
    end

    always_comb begin
        c2_d = c2_q;
        if (wr2) begin
            c2_d.multi_pkt = wr_data[4];
            c2_d.direct    = wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c1_q <= '0;
            c2_q <= '0;
        end else begin
            c1_q <= c1_d;
            c2_q <= c2_d;
        end
    end

    // R6: a TX exit clears the transmit-enable unless the host overwrites it
    assert_txen_cleared_R6: assert property (@(posedge clk) disable iff (rst)
        exit_tx && !wr1 |=> !c1_q.tx_en);

    // R7: an RX exit clears the receive-enable unless the host overwrites it
    assert_rxen_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        exit_rx && !wr1 |=> !c1_q.rx_en);

endmodule

// File: rtl/xcvr_settle_timer.sv
module xcvr_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt <= W'(1));

    // R4: the sequencer never counts down past the last settle cycle
    assert_no_underrun_R4: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt > W'(1)));

endmodule

// File: rtl/xcvr_mode_fsm.sv
module xcvr_mode_fsm
    import xcvr_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl1_t c1_d,
    input  ctl2_t c2_q,
    input  logic  pkt_sent,
    input  logic  pkt_valid,
    input  logic  done,
    output logic  load,
    output logic  dec,
    output logic  exit_tx,
    output logic  exit_rx,
    output mode_e mode_q
);

    mode_e want, nxt;

    assign want    = target_of(c1_d);
    assign exit_tx = (mode_q == M_TX) && pkt_sent && !c2_q.direct;
    assign exit_rx = (mode_q == M_RX) && pkt_valid && !c2_q.direct && !c2_q.multi_pkt;

    always_comb begin
        nxt  = mode_q;
        load = 1'b0;
        dec  = 1'b0;
        if (!is_active(want)) begin
            nxt = want;
        end else if (mode_q == want) begin
            nxt = mode_q;
        end else if (mode_q == M_SETTLE) begin
            if (done) nxt = want;
            else      dec = 1'b1;
        end else begin
            nxt  = M_SETTLE;
            load = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= M_STBY;
        else     mode_q <= nxt;
    end

    // R8: RX persists while only the receive-enable stays set
    assert_rx_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_RX) && c1_d.rx_en && !c1_d.tx_en |=> (mode_q == M_RX));

endmodule

// File: rtl/xcvr_mode_seq.sv
module xcvr_mode_seq
    import xcvr_mode_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                pkt_sent,
    input  logic                pkt_valid,
    output logic [1:0]          state_o,
    output logic [7:0]          ctl1_o
);

    ctl1_t c1_q, c1_d;
    ctl2_t c2_q;
    mode_e mode_q;
    logic  load, dec, done, exit_tx, exit_rx;

    xcvr_ctl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .exit_tx (exit_tx),
        .exit_rx (exit_rx),
        .c1_q    (c1_q),
        .c1_d    (c1_d),
        .c2_q    (c2_q)
    );

    xcvr_settle_timer #(.W(SETTLE_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (settle_cycles),
        .dec      (dec),
        .done     (done)
    );

    xcvr_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .c1_d      (c1_d),
        .c2_q      (c2_q),
        .pkt_sent  (pkt_sent),
        .pkt_valid (pkt_valid),
        .done      (done),
        .load      (load),
        .dec       (dec),
        .exit_tx   (exit_tx),
        .exit_rx   (exit_rx),
        .mode_q    (mode_q)
    );

    assign state_o = code_of(mode_q);
    assign ctl1_o  = {5'b0, c1_q.tx_en, c1_q.rx_en, c1_q.pll_on};

    // R5: RX is never shown while transmit-enable is stored
    assert_tx_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o == CODE_RX) |-> !ctl1_o[2]);

    // R6: a packet-sent pulse in TX leaves TX in packet-buffer mode
    assert_tx_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (state_o == CODE_TX) && pkt_sent && !wr_en && !c2_q.direct
        |=> (state_o != CODE_TX) && !ctl1_o[2]);

    // R11: clearing both enables lands in an idle state at once
    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_addr == CTL1_ADDR) && (wr_data[2:1] == 2'b00)
        |=> (state_o == CODE_STBY) || (state_o == CODE_TUNE));

endmodule

// File: tb/xcvr_mode_seq_tb.sv
module xcvr_mode_seq_tb;

    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic [SW-1:0] settle_cycles = '0;
    logic          pkt_sent = 1'b0;
    logic          pkt_valid = 1'b0;
    logic [1:0]    state_o;
    logic [7:0]    ctl1_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xcvr_mode_seq #(.SETTLE_W(SW)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .settle_cycles (settle_cycles),
        .pkt_sent      (pkt_sent),
        .pkt_valid     (pkt_valid),
        .state_o       (state_o),
        .ctl1_o        (ctl1_o)
    );

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(logic a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse(bit sent);
        if (sent) pkt_sent = 1'b1; else pkt_valid = 1'b1;
        tick();
        pkt_sent = 1'b0; pkt_valid = 1'b0;
    endtask

    task automatic settle_check(string req, int s, int code);
        int len;
        len = (s < 1) ? 1 : s;
        for (int i = 0; i < len; i++) begin
            chk(req, state_o, 1);
            tick();
        end
        chk(req, state_o, code);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1 state", state_o, 0);
        chk("R1 ctl1", ctl1_o, 0);

        // R2: unused bits read 0, R3 idle selection
        wr(0, 8'hF8);
        chk("R2 unused bits", ctl1_o, 0);
        chk("R3 standby", state_o, 0);
        wr(0, 8'h01);
        chk("R2 pll bit", ctl1_o, 1);
        chk("R3 tune idle", state_o, 1);
        wr(0, 8'h00);
        chk("R3 back to standby", state_o, 0);

        // R4 settle sweep, R11 abort from active
        for (int s = 0; s < 6; s++) begin
            for (int pll = 0; pll < 2; pll++) begin
                for (int md = 0; md < 2; md++) begin
                    int en;
                    en = md ? 4 : 2;
                    settle_cycles = SW'(s);
                    wr(0, 8'(pll));
                    chk("R3 idle", state_o, pll);
                    wr(0, 8'(pll | en));
                    settle_check("R4 settle", s, md ? 3 : 2);
                    chk("R2 ctl1", ctl1_o, pll | en);
                    wr(0, 8'(pll));
                    chk("R11 abort active", state_o, pll);
                end
            end
        end

        // R11 abort during settle
        settle_cycles = SW'(4);
        wr(0, 8'h04);
        chk("R11 settle start", state_o, 1);
        wr(0, 8'h00);
        for (int i = 0; i < 5; i++) begin
            chk("R11 abort settle", state_o, 0);
            tick();
        end

        // R6..R10 event sweep
        settle_cycles = SW'(2);
        for (int dir = 0; dir < 2; dir++) begin
            for (int mpk = 0; mpk < 2; mpk++) begin
                for (int pll = 0; pll < 2; pll++) begin
                    for (int md = 0; md < 2; md++) begin
                        int en, act, exp_state, exp_ctl;
                        en  = md ? 4 : 2;
                        act = md ? 3 : 2;
                        wr(1, 8'((mpk << 4) | dir));
                        wr(0, 8'(pll | en));
                        chk("R4 settle entry", state_o, 1);
                        pulse(md == 1);
                        chk("R9 event in settle ctl", ctl1_o, pll | en);
                        chk("R9 event in settle state", state_o, 1);
                        tick();
                        chk("R4 active", state_o, act);
                        pulse(md == 0);
                        chk("R9 other event state", state_o, act);
                        chk("R9 other event ctl", ctl1_o, pll | en);
                        pulse(md == 1);
                        if (dir == 1) begin
                            exp_state = act; exp_ctl = pll | en;
                        end else if (md == 1) begin
                            exp_state = pll; exp_ctl = pll;
                        end else if (mpk == 1) begin
                            exp_state = act; exp_ctl = pll | en;
                        end else begin
                            exp_state = pll; exp_ctl = pll;
                        end
                        if (dir == 1) begin
                            chk("R10 direct state", state_o, exp_state);
                            chk("R10 direct ctl", ctl1_o, exp_ctl);
                        end else if (md == 1) begin
                            chk("R6 tx exit state", state_o, exp_state);
                            chk("R6 tx exit ctl", ctl1_o, exp_ctl);
                        end else if (mpk == 1) begin
                            chk("R8 multi state", state_o, exp_state);
                            chk("R8 multi ctl", ctl1_o, exp_ctl);
                        end else begin
                            chk("R7 rx exit state", state_o, exp_state);
                            chk("R7 rx exit ctl", ctl1_o, exp_ctl);
                        end
                        wr(0, 8'h00);
                        wr(1, 8'h00);
                    end
                end
            end
        end

        // R5 priority and hand-over to RX
        settle_cycles = SW'(2);
        wr(0, 8'h06);
        settle_check("R5 tx wins", 2, 3);
        pulse(0);
        chk("R5 rx ignored", state_o, 3);
        pulse(1);
        chk("R5 ctl after tx exit", ctl1_o, 2);
        settle_check("R5 rx takes over", 2, 2);
        wr(0, 8'h06);
        settle_check("R5 tx from rx", 2, 3);
        wr(0, 8'h00);
        chk("R11 final abort", state_o, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule